// File: doc/BRIEF.md
# Bucketed Partition Writer

This block takes a stream of 64-bit tuples (a 32-bit key and a 32-bit payload) from a show-ahead input FIFO and routes each one to one of `NPART` partitions. The partition is chosen by the low-order bits of the key. Each partition owns a small on-chip bucket of `SLOTS` entries and a private tuple counter. Because all of this state belongs to this one writer, it needs no locks or arbitration.

When a bucket fills, the whole bucket leaves as a single burst of `SLOTS` beats on a valid/ready write master. The burst goes to the partition's next free address, so each partition's output lands contiguously starting at its base address. This gives one memory transaction per `SLOTS` tuples, where writing tuples one at a time would give one transaction per tuple. A new tuple is accepted at most once every `II` cycles, which is the commit time of the counter and bucket update. When the end of input is signalled and the FIFO has drained, the partly filled buckets are flushed in partition order. After that, `done` rises and the per-partition counters can be read out.

Control is a five-state machine:
- **ST_ACCEPT**: takes tuples. It moves to ST_EMIT_FULL when a bucket fills. It moves to ST_SCAN when the FIFO is empty and end of input is high.
- **ST_EMIT_FULL**: streams a full bucket, then returns to ST_ACCEPT.
- **ST_SCAN**: walks the partitions. It goes to ST_EMIT_PART for a non-empty bucket, and to ST_DONE after the last partition.
- **ST_EMIT_PART**: streams a partial bucket, then goes back to ST_SCAN, or to ST_DONE if this was the last partition.
- **ST_DONE**: holds until reset.

Top module: `part_bucket_writer`

## Requirements
- R1: After reset, `in_rd`, `wr_valid`, `wr_last` and `done` are 0, and every partition count reads 0.
- R2: A tuple's partition is `in_key[PW-1:0]`, where PW = log2(NPART). Each accepted tuple adds one to that partition's count only.
- R3: When a partition's bucket reaches SLOTS tuples, it is written as one burst of SLOTS beats. The beats come in arrival order, each beat's data is `{key, payload}` with the key in the upper 32 bits, and `wr_last` is high only on the final beat.
- R4: Every beat of a burst for partition p carries address `base[p] + k*SLOTS*8`, where k is the number of bursts already written for p since reset. `base[p]` is `part_base[p*ADDR_W +: ADDR_W]`.
- R5: Two FIFO pops are at least II cycles apart (II = 7 by default).
- R6: No tuple is popped while a burst is being written.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_last` hold their values.
- R8: Once `in_end` is high and the FIFO is empty, each non-empty bucket is written as one burst of exactly its fill count, in increasing partition order. Empty buckets produce no burst. `done` rises only after the last of these bursts.
- R9: After `done`, `cnt_out` for `cnt_sel = p` equals the number of tuples routed to partition p.
- R10: Once high, `done` stays high until reset. After that, no tuple is popped and no beat is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_empty | input | 1 | Input FIFO empty |
| in_rd | output | 1 | Pop the current FIFO head |
| in_key | input | KEY_W | Key at the FIFO head |
| in_pay | input | PAY_W | Payload at the FIFO head |
| in_end | input | 1 | End of input; level, held until reset |
| part_base | input | NPART*ADDR_W | Per-partition base byte addresses |
| wr_valid | output | 1 | Burst beat valid |
| wr_ready | input | 1 | Memory side accepts the beat |
| wr_addr | output | ADDR_W | Burst start address |
| wr_data | output | KEY_W+PAY_W | Beat data `{key, payload}` |
| wr_last | output | 1 | Final beat of the burst |
| cnt_sel | input | PW | Partition selected for count readout |
| cnt_out | output | CNT_W | Tuple count of the selected partition |
| done | output | 1 | All buckets flushed |

## Verification
The bench sends three kinds of traffic, each aimed at a different fault:
- **Single-partition stream.** Every tuple goes to one partition, giving back-to-back full buckets. This separates correct address advance from a stuck or wrong-stride flush counter.
- **Round-robin keys under an intermittent `wr_ready`.** Buckets fill in lockstep, so a swapped partition index, a broken beat order or a failure to hold a stalled beat shows up as a data mismatch.
- **Mixed keys ending with one partition empty.** This checks the end-of-input flush: partial burst lengths, increasing partition order and skipping the empty bucket.

A second run after reset, with a lone partial bucket in the highest partition, confirms that the counts clear and that a short final burst ends on the right beat.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    typedef enum logic [2:0] {
        ST_ACCEPT,
        ST_EMIT_FULL,
        ST_SCAN,
        ST_EMIT_PART,
        ST_DONE
    } pbw_state_e;
endpackage

// File: rtl/pbw_pace.sv
// Initiation-interval limiter: after a start, ready stays low for II-1 cycles.
module pbw_pace #(
    parameter int II = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = (II > 1) ? $clog2(II) : 1;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              wait_q <= '0;
        else if (start)          wait_q <= CW'(II - 1);
        else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
    end

    assign ready = (wait_q == '0);
endmodule

// File: rtl/pbw_bucket_mem.sv
// Bucket storage: NPART buckets of SLOTS tuples, one write and one read port.
module pbw_bucket_mem #(
    parameter int NPART = 4,
    parameter int SLOTS = 4,
    parameter int W     = 64,
    localparam int PW   = $clog2(NPART),
    localparam int BW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wpart,
    input  logic [BW-1:0] wslot,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] rpart,
    input  logic [BW-1:0] rslot,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [NPART][SLOTS];

    always_ff @(posedge clk) begin
        if (we) mem[wpart][wslot] <= wdata;
    end

    assign rdata = mem[rpart][rslot];
endmodule

// File: rtl/part_bucket_writer.sv
module part_bucket_writer
    import pbw_pkg::*;
#(
    parameter int KEY_W  = 32,
    parameter int PAY_W  = 32,
    parameter int NPART  = 4,
    parameter int SLOTS  = 4,
    parameter int II     = 7,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int PW    = $clog2(NPART),
    localparam int TUP_W = KEY_W + PAY_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_empty,
    output logic                    in_rd,
    input  logic [KEY_W-1:0]        in_key,
    input  logic [PAY_W-1:0]        in_pay,
    input  logic                    in_end,
    input  logic [NPART*ADDR_W-1:0] part_base,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [TUP_W-1:0]        wr_data,
    output logic                    wr_last,
    input  logic [PW-1:0]           cnt_sel,
    output logic [CNT_W-1:0]        cnt_out,
    output logic                    done
);
    localparam int SW          = $clog2(SLOTS + 1);
    localparam int BW          = $clog2(SLOTS);
    localparam int BURST_BYTES = SLOTS * (TUP_W / 8);

    pbw_state_e state_q, state_d;

    logic [PW-1:0]     cur_q;
    logic [SW-1:0]     beat_q;
    logic [SW-1:0]     fill_q   [NPART];
    logic [ADDR_W-1:0] nflush_q [NPART];
    logic [CNT_W-1:0]  count_q  [NPART];

    logic          pace_ok, pop, fills_now, last_beat, beat_go;
    logic [PW-1:0] pidx;
    logic [SW-1:0] burst_len;

    assign pidx      = in_key[PW-1:0];
    assign pop       = (state_q == ST_ACCEPT) && !in_empty && pace_ok;
    assign fills_now = (fill_q[pidx] == SW'(SLOTS - 1));
    assign burst_len = (state_q == ST_EMIT_PART) ? fill_q[cur_q] : SW'(SLOTS);
    assign last_beat = ((beat_q + SW'(1)) == burst_len);
    assign beat_go   = wr_valid && wr_ready;

    pbw_pace #(.II(II)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pop),
        .ready (pace_ok)
    );

    pbw_bucket_mem #(.NPART(NPART), .SLOTS(SLOTS), .W(TUP_W)) u_mem (
        .clk   (clk),
        .we    (pop),
        .wpart (pidx),
        .wslot (fill_q[pidx][BW-1:0]),
        .wdata ({in_key, in_pay}),
        .rpart (cur_q),
        .rslot (beat_q[BW-1:0]),
        .rdata (wr_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACCEPT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: begin
                if (pop && fills_now)         state_d = ST_EMIT_FULL;
                else if (in_empty && in_end)  state_d = ST_SCAN;
            end
            ST_EMIT_FULL: begin
                if (beat_go && last_beat)     state_d = ST_ACCEPT;
            end
            ST_SCAN: begin
                if (fill_q[cur_q] != '0)                  state_d = ST_EMIT_PART;
                else if (cur_q == PW'(NPART - 1))         state_d = ST_DONE;
            end
            ST_EMIT_PART: begin
                if (beat_go && last_beat)
                    state_d = (cur_q == PW'(NPART - 1)) ? ST_DONE : ST_SCAN;
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_ACCEPT;
        endcase
    end

    // Output logic
    always_comb begin
        in_rd    = pop;
        wr_valid = (state_q == ST_EMIT_FULL) || (state_q == ST_EMIT_PART);
        wr_last  = wr_valid && last_beat;
        done     = (state_q == ST_DONE);
        wr_addr  = part_base[cur_q*ADDR_W +: ADDR_W]
                 + nflush_q[cur_q] * ADDR_W'(BURST_BYTES);
        cnt_out  = count_q[cnt_sel];
    end

    // Per-partition bookkeeping and burst cursor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            beat_q <= '0;
            for (int p = 0; p < NPART; p++) begin
                fill_q[p]   <= '0;
                nflush_q[p] <= '0;
                count_q[p]  <= '0;
            end
        end else begin
            if (pop) begin
                fill_q[pidx]  <= fill_q[pidx] + SW'(1);
                count_q[pidx] <= count_q[pidx] + CNT_W'(1);
                if (fills_now) begin
                    cur_q  <= pidx;
                    beat_q <= '0;
                end
            end
            if (state_q == ST_ACCEPT && in_empty && in_end) cur_q <= '0;
            if (state_q == ST_SCAN && fill_q[cur_q] == '0 && cur_q != PW'(NPART - 1))
                cur_q <= cur_q + PW'(1);
            if (beat_go) begin
                if (last_beat) begin
                    beat_q          <= '0;
                    fill_q[cur_q]   <= '0;
                    nflush_q[cur_q] <= nflush_q[cur_q] + ADDR_W'(1);
                    if (state_q == ST_EMIT_PART && cur_q != PW'(NPART - 1))
                        cur_q <= cur_q + PW'(1);
                end else begin
                    beat_q <= beat_q + SW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
    parameter int II     = 7,
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 32,
    parameter int TUP_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_rd,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [TUP_W-1:0]  wr_data,
    input logic              wr_last,
    input logic              done
);
    int gap_q;
    int beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= II;
            beats_q <= 0;
        end else begin
            if (in_rd)            gap_q <= 1;
            else if (gap_q < II)  gap_q <= gap_q + 1;
            if (wr_valid && wr_ready) beats_q <= wr_last ? 0 : beats_q + 1;
        end
    end

    AST_PACE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> gap_q >= II); // R5
    AST_NO_POP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_rd); // R6
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last))); // R7
    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_last) |-> beats_q < SLOTS - 1); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_rd && !wr_valid)); // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R10
endmodule

bind part_bucket_writer pbw_checker #(
    .II(II), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .TUP_W(TUP_W)
) u_pbw_checker (
    .clk(clk), .rst_n(rst_n), .in_rd(in_rd), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_last(wr_last), .done(done)
);

// File: tb/part_bucket_writer_bench.sv
module part_bucket_writer_bench;
    localparam int NPART  = 4;
    localparam int SLOTS  = 4;
    localparam int II     = 7;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int ENT_W  = ADDR_W + 64 + 1;

    logic clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic                    rst_n, in_empty, in_rd, in_end;
    logic [31:0]             in_key, in_pay;
    logic [NPART*ADDR_W-1:0] part_base;
    logic                    wr_valid, wr_ready, wr_last, done;
    logic [ADDR_W-1:0]       wr_addr;
    logic [63:0]             wr_data;
    logic [1:0]              cnt_sel;
    logic [CNT_W-1:0]        cnt_out;

    part_bucket_writer u_part_bucket_writer (
        .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd),
        .in_key(in_key), .in_pay(in_pay), .in_end(in_end), .part_base(part_base),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_last(wr_last), .cnt_sel(cnt_sel),
        .cnt_out(cnt_out), .done(done)
    );

    // Show-ahead input FIFO model
    logic [63:0] fifo_mem [64];
    logic [5:0]  f_head, f_tail;
    assign in_empty = (f_head == f_tail);
    assign in_key   = fifo_mem[f_head][63:32];
    assign in_pay   = fifo_mem[f_head][31:0];
    always_ff @(posedge clk) begin
        if (!rst_n)     f_head <= '0;
        else if (in_rd) f_head <= f_head + 6'd1;
    end

    int n_cmp = 0, n_bad = 0;
    string phase_req = "R3 R4";
    logic stall_en = 1'b0;
    logic finished = 1'b0;

    // Reference model and expected beat queue
    logic [63:0] m_buf [NPART][SLOTS];
    int m_fill [NPART], m_flush [NPART], m_cnt [NPART];
    logic [ENT_W-1:0] exp_q [$];

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] base_of(input int p);
        return part_base[p*ADDR_W +: ADDR_W];
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NPART; p++) begin
            m_fill[p] = 0; m_flush[p] = 0; m_cnt[p] = 0;
        end
        exp_q.delete();
    endtask

    task automatic emit_bucket(input int p, input int n);
        for (int s = 0; s < n; s++) begin
            logic [ADDR_W-1:0] a;
            a = base_of(p) + ADDR_W'(m_flush[p] * SLOTS * 8);
            exp_q.push_back({a, m_buf[p][s], (s == n - 1)});
        end
        m_flush[p]++;
        m_fill[p] = 0;
    endtask

    // Driver: push a tuple into the FIFO and the expected stream
    task automatic push_tup(input logic [31:0] key, input logic [31:0] pay);
        int p;
        p = int'(key[1:0]); // R2: partition from low key bits
        m_buf[p][m_fill[p]] = {key, pay};
        m_fill[p]++;
        m_cnt[p]++;
        if (m_fill[p] == SLOTS) emit_bucket(p, SLOTS);
        @(negedge clk);
        fifo_mem[f_tail] = {key, pay};
        f_tail = f_tail + 6'd1;
    endtask

    task automatic model_flush();
        for (int p = 0; p < NPART; p++)
            if (m_fill[p] > 0) emit_bucket(p, m_fill[p]);
    endtask

    // Monitor: ready pattern, beat compare, pacing
    int cyc = 0;
    int pop_gap = 100;
    always @(negedge clk) begin
        cyc++;
        wr_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
        if (rst_n && !finished) begin
            pop_gap++;
            if (in_rd) begin
                check(pop_gap >= II, "R5 pop gap", 128'(pop_gap), 128'(II));
                check(!wr_valid, "R6 pop during burst", 128'(wr_valid), 128'(0));
                check(!done, "R10 pop after done", 128'(done), 128'(0));
                pop_gap = 0;
            end
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected beat", 128'(wr_data), 128'(0));
                end else begin
                    logic [ENT_W-1:0] e;
                    e = exp_q.pop_front();
                    check(wr_addr == e[ENT_W-1 -: ADDR_W], {phase_req, " addr"}, 128'(wr_addr), 128'(e[ENT_W-1 -: ADDR_W]));
                    check(wr_data == e[64:1], {phase_req, " data"}, 128'(wr_data), 128'(e[64:1]));
                    check(wr_last == e[0], {phase_req, " last"}, 128'(wr_last), 128'(e[0]));
                end
            end
        end
    end

    task automatic wait_drain();
        while (exp_q.size() != 0 || !in_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_end = 1'b0;
        f_tail = '0;
        model_reset();
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!in_rd && !wr_valid && !wr_last && !done, "R1 outputs idle",
              128'({in_rd, wr_valid, wr_last, done}), 128'(0));
        for (int p = 0; p < NPART; p++) begin
            cnt_sel = 2'(p);
            #1;
            check(cnt_out == '0, "R1 count clear", 128'(cnt_out), 128'(0));
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_counts();
        for (int p = 0; p < NPART; p++) begin
            cnt_sel = 2'(p);
            @(negedge clk);
            check(cnt_out == CNT_W'(m_cnt[p]), "R9 R2 partition count", 128'(cnt_out), 128'(m_cnt[p]));
        end
    endtask

    initial begin
        part_base = {32'h0000_4000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000};
        cnt_sel = '0;
        wr_ready = 1'b1;
        do_reset();

        // Pattern A: single partition, back-to-back full buckets (R3 R4)
        phase_req = "R3 R4 single-partition";
        for (int i = 0; i < 8; i++) push_tup(32'(i * 4 + 1), 32'hA000_0000 + 32'(i));
        wait_drain();

        // Pattern B: round-robin with stalling ready (R3 R4 R7)
        stall_en = 1'b1;
        phase_req = "R3 R4 R7 round-robin";
        for (int i = 0; i < 16; i++) push_tup(32'(i), 32'hB000_0000 + 32'(i));
        wait_drain();

        // Pattern C: mixed partials, partition 2 empty at end (R8)
        phase_req = "R8 flush";
        push_tup(32'h13, 32'hC1); push_tup(32'h20, 32'hC2); push_tup(32'h27, 32'hC3);
        push_tup(32'h31, 32'hC4); push_tup(32'h44, 32'hC5); push_tup(32'h5B, 32'hC6);
        model_flush();
        in_end = 1'b1;
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R8 done after last flush", 128'(exp_q.size()), 128'(0));
        check_counts();

        // R10: done sticky, input ignored
        push_tup(32'h2, 32'hD1);
        push_tup(32'h6, 32'hD2);
        repeat (30) @(negedge clk);
        check(done, "R10 done sticky", 128'(done), 128'(1));
        check((f_tail - f_head) == 6'd2, "R10 no pops after done", 128'(f_tail - f_head), 128'(2));
        check(exp_q.size() == 0, "R10 no writes after done", 128'(exp_q.size()), 128'(0));

        // Second run: counts clear, lone short burst in top partition (R1 R8)
        stall_en = 1'b0;
        do_reset();
        phase_req = "R8 short final burst";
        push_tup(32'h3, 32'hE1); push_tup(32'h7, 32'hE2); push_tup(32'hB, 32'hE3);
        model_flush();
        in_end = 1'b1;
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R8 all beats seen", 128'(exp_q.size()), 128'(0));
        check_counts();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule